// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start-Bit Qualification

This block turns an asynchronous serial line into parallel characters. It watches the line on every pulse of a 16x oversampling tick. A falling edge only begins a character if the line is still low halfway through the start bit. Each following bit is decided by a two-of-three vote around the middle of the bit. Each character has 5 to 8 data bits, sent least significant bit first, and may carry an even or odd parity bit. The finished character is moved into a one-entry receive buffer as soon as the first stop bit has been sampled, without waiting for the rest of the stop interval.

The buffer leaves the block on a valid/ready interface. `rx_valid` is the receive-complete flag and `rx_ready` is the read strobe. A read happens on a clock where both are high, and the flag clears on the next clock. Back-pressure has no effect on the line side. The receiver never stalls: a character that completes while the buffer is still unread replaces the stored one, and `rx_valid` stays high. The framing and parity status bits belong to the buffered character and change only when a new character is transferred. The receive enable hands the line to the receiver; with it low, the receiver stays idle and drops any character in progress.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `rx_valid`, `rx_frame_err` and `rx_parity_err` are 0 and `rx_data` is 0.
- R2: A low level on `rxd` starts a character only if the sample taken at oversample tick 8 after the first low tick is still low. A low pulse of 8 ticks or fewer produces no character.
- R3: Each data, parity and stop bit is the majority of the samples at oversample ticks 7, 8 and 9 of that bit. A single wrong sample at one of those ticks does not change the received value.
- R4: `cfg_data_len` selects the number of data bits: 0=5, 1=6, 2=7, 3=8. Bits arrive LSB first and land in `rx_data[0]` upward. Buffer bits at and above the length read as 0.
- R5: With `cfg_parity_en`=1, one parity bit follows the last data bit. `cfg_parity_odd`=0 selects even parity and 1 selects odd. `rx_parity_err` is 1 when the parity bit does not match the data, and it is 0 when parity is disabled.
- R6: `rx_frame_err` is 1 when the first stop bit votes low. The character is still transferred.
- R7: The transfer to the buffer happens one clock after the oversample tick that takes sample 9 of the first stop bit. No later bit time is examined, so a configured second stop bit is never checked.
- R8: `rx_valid` sets on a transfer. It clears one clock after a cycle with `rx_valid` and `rx_ready` both high. While unread, the flag and the buffer contents hold. A new transfer replaces the buffer and keeps `rx_valid` at 1.
- R9: While `rx_en` is 0 the receiver ignores `rxd`, and a character that is in progress when `rx_en` falls is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| os_tick | input | 1 | One-clock pulse at 16x the bit rate |
| rxd | input | 1 | Serial line input, idle high |
| cfg_data_len | input | 2 | Data bit count: 0=5 up to 3=8 |
| cfg_parity_en | input | 1 | A parity bit follows the data |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rx_valid | output | 1 | Receive-complete flag, valid of the buffer stream |
| rx_ready | input | 1 | Read strobe, ready of the buffer stream |
| rx_data | output | 8 | Buffered character, zero-extended |
| rx_frame_err | output | 1 | First stop bit of the buffered character was low |
| rx_parity_err | output | 1 | Parity mismatch on the buffered character |

## Verification
The buffered character and its status are due one clock after the oversample tick that takes sample 9 of the first stop bit. The bench drives the line one tick slot at a time. It checks that `rx_valid` is still low just before that tick. It then checks the flag, data and status after the tick for slot 10 has been consumed, which is still well inside the first stop bit. A read clears the flag one clock after the strobe, so the flag is checked one cycle after `rx_ready` is released. For rejected starts and disabled reception, the flag is checked only after enough idle tick slots have passed to cover any character that could have started.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_MAX = 8;
  localparam int unsigned DATA_MIN = 5;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_bitclk.sv
module uart_rx_bitclk #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic rxs,
  output logic mid_tick,
  output logic vote_tick,
  output logic last_tick,
  output logic vote_bit
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned MID = OVS / 2;

  logic [CW-1:0] cnt;
  logic          s_early, s_mid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_early <= 1'b1;
      s_mid   <= 1'b1;
    end else begin
      if (tick && cnt == CW'(MID - 1)) s_early <= rxs;
      if (tick && cnt == CW'(MID))     s_mid   <= rxs;
    end
  end

  assign mid_tick  = tick && (cnt == CW'(MID));
  assign vote_tick = tick && (cnt == CW'(MID + 1));
  assign last_tick = tick && (cnt == CW'(OVS - 1));
  assign vote_bit  = (s_early & s_mid) | (s_early & rxs) | (s_mid & rxs);

  // R3: the vote position is reached only while a character is running
  assert_vote_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vote_tick |-> run);
  // R3: the oversample counter stays inside one bit time
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < OVS);
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       tick,
  input  logic       rxs,
  input  logic       mid_tick,
  input  logic       vote_tick,
  input  logic       last_tick,
  input  logic       vote_bit,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  output logic       run,
  output logic       load,
  output logic [DATA_MAX-1:0] ld_data,
  output logic       ld_ferr,
  output logic       ld_perr
);
  rx_state_e           state;
  logic [2:0]          bit_idx;
  logic [1:0]          len_q;
  logic                par_en_q, par_odd_q, par_acc, perr_q;
  logic [DATA_MAX-1:0] shreg;
  logic                start_now;

  assign start_now = rx_en && tick && !rxs && (state == ST_IDLE);
  assign run       = (state != ST_IDLE) || start_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_idx   <= '0;
      len_q     <= '0;
      par_en_q  <= 1'b0;
      par_odd_q <= 1'b0;
      par_acc   <= 1'b0;
      perr_q    <= 1'b0;
      shreg     <= '0;
      load      <= 1'b0;
      ld_data   <= '0;
      ld_ferr   <= 1'b0;
      ld_perr   <= 1'b0;
    end else begin
      load <= 1'b0;
      if (!rx_en) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (start_now) begin
            state     <= ST_START;
            len_q     <= cfg_len;
            par_en_q  <= cfg_par_en;
            par_odd_q <= cfg_par_odd;
            par_acc   <= 1'b0;
            perr_q    <= 1'b0;
            bit_idx   <= '0;
          end
          ST_START: begin
            if (mid_tick && rxs) state <= ST_IDLE;
            else if (last_tick)  state <= ST_DATA;
          end
          ST_DATA: begin
            if (vote_tick) begin
              shreg   <= {vote_bit, shreg[DATA_MAX-1:1]};
              par_acc <= par_acc ^ vote_bit;
            end
            if (last_tick) begin
              bit_idx <= bit_idx + 3'd1;
              if (bit_idx == {1'b1, len_q}) state <= par_en_q ? ST_PARITY : ST_STOP;
            end
          end
          ST_PARITY: begin
            if (vote_tick) perr_q <= par_acc ^ vote_bit ^ par_odd_q;
            if (last_tick) state <= ST_STOP;
          end
          ST_STOP: if (vote_tick) begin
            load    <= 1'b1;
            ld_data <= shreg >> (2'd3 - len_q);
            ld_ferr <= !vote_bit;
            ld_perr <= par_en_q & perr_q;
            state   <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R9: a disabled receiver is idle and transfers nothing
  assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (state == ST_IDLE) && !load);
  // R2: a high mid-start sample abandons the character
  assert_start_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && state == ST_START && mid_tick && rxs) |=> state == ST_IDLE);
  // R7: transfers come only from the first stop bit
  assert_load_from_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> $past(state) == ST_STOP);
  // R4: bits above the configured length are zero
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (({24'b0, ld_data} >> (32'(len_q) + 32'd5)) == 32'd0));
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_ferr,
  input  logic          ld_perr,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_ferr,
  output logic          out_perr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ferr  <= 1'b0;
      out_perr  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
      out_ferr  <= ld_ferr;
      out_perr  <= ld_perr;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a transfer raises the flag
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);
  // R8: a read with no new transfer drops the flag
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load) |=> !out_valid);
  // R8: an unread buffer holds still
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load) |=> out_valid && $stable(out_data)
      && $stable(out_ferr) && $stable(out_perr));
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic [1:0] cfg_data_len,
  input  logic       cfg_parity_en,
  input  logic       cfg_parity_odd,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_frame_err,
  output logic       rx_parity_err
);
  logic rxs, run, mid_tick, vote_tick, last_tick, vote_bit;
  logic load, ld_ferr, ld_perr;
  logic [DATA_MAX-1:0] ld_data;

  uart_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxs)
  );

  uart_rx_bitclk #(.OVS(OVS)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .run(run), .rxs(rxs),
    .mid_tick(mid_tick), .vote_tick(vote_tick), .last_tick(last_tick),
    .vote_bit(vote_bit)
  );

  uart_rx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(os_tick), .rxs(rxs),
    .mid_tick(mid_tick), .vote_tick(vote_tick), .last_tick(last_tick),
    .vote_bit(vote_bit), .cfg_len(cfg_data_len), .cfg_par_en(cfg_parity_en),
    .cfg_par_odd(cfg_parity_odd), .run(run), .load(load), .ld_data(ld_data),
    .ld_ferr(ld_ferr), .ld_perr(ld_perr)
  );

  uart_rx_buf #(.DW(DATA_MAX)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_data(ld_data),
    .ld_ferr(ld_ferr), .ld_perr(ld_perr), .out_ready(rx_ready),
    .out_valid(rx_valid), .out_data(rx_data), .out_ferr(rx_frame_err),
    .out_perr(rx_parity_err)
  );

  // R1: nothing is flagged in the first cycle out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !rx_valid && !rx_frame_err && !rx_parity_err);
endmodule

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;
  logic       clk = 1'b0;
  logic       rst_n, rx_en, os_tick, rxd, rx_ready;
  logic [1:0] cfg_data_len;
  logic       cfg_parity_en, cfg_parity_odd;
  logic       rx_valid, rx_frame_err, rx_parity_err;
  logic [7:0] rx_data;
  logic [1:0] tdiv;
  int         checks = 0;
  int         fails  = 0;

  always #2 clk = ~clk;

  uart_rx_core i_uart_rx_core (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
    .cfg_data_len(cfg_data_len), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_odd(cfg_parity_odd), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdiv    <= '0;
      os_tick <= 1'b0;
    end else begin
      tdiv    <= tdiv + 2'd1;
      os_tick <= (tdiv == 2'd3);
    end
  end

  function automatic logic [7:0] exp_data(input logic [7:0] d, input logic [1:0] lc);
    return d & 8'((9'd1 << (5 + lc)) - 9'd1);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] lc, input logic odd);
    return (^exp_data(d, lc)) ^ odd;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one tick slot: value is seen by the receiver at the following tick
  task automatic next_slot(input logic v);
    do @(negedge clk); while (!os_tick);
    @(posedge clk);
    #1 rxd = v;
  endtask

  task automatic send_bit(input logic v, input int gslot);
    for (int s = 0; s < 16; s++) next_slot((s == gslot) ? ~v : v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) next_slot(1'b1);
  endtask

  // timed: check the flag is low before stop sample 9 and high after it
  task automatic send_frame(input logic [7:0] d, input logic pflip, input logic stopv,
                            input int gbit, input int gslot, input bit timed);
    int n;
    n = 5 + int'(cfg_data_len);
    send_bit(1'b0, -1);
    for (int i = 0; i < n; i++) send_bit(d[i], (i == gbit) ? gslot : -1);
    if (cfg_parity_en) send_bit(par_bit(d, cfg_data_len, cfg_parity_odd) ^ pflip,
                                (gbit == n) ? gslot : -1);
    for (int s = 0; s < 16; s++) begin
      next_slot(stopv);
      if (timed && s == 9)  chk("R7 flag before stop mid-sample", 32'(rx_valid), 32'd0);
      if (timed && s == 11) chk("R7 flag after stop mid-sample", 32'(rx_valid), 32'd1);
    end
    idle(6);
  endtask

  task automatic read_out;
    #1 rx_ready = 1'b1;
    @(posedge clk);
    #1 rx_ready = 1'b0;
    chk("R8 flag clears after read", 32'(rx_valid), 32'd0);
  endtask

  task automatic check_frame(input logic [7:0] d, input logic pflip, input logic stopv);
    chk("R4 data", 32'(rx_data), 32'(exp_data(d, cfg_data_len)));
    chk("R5 parity error", 32'(rx_parity_err), 32'(cfg_parity_en & pflip));
    chk("R6 frame error", 32'(rx_frame_err), 32'(!stopv));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    logic       pf, sv;
    int         gb, gs;
    void'($urandom(32'h1d5e_a7c3));
    rst_n = 1'b0; rx_en = 1'b1; rxd = 1'b1; rx_ready = 1'b0;
    cfg_data_len = 2'd3; cfg_parity_en = 1'b0; cfg_parity_odd = 1'b0;
    repeat (6) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset valid", 32'(rx_valid), 32'd0);
    chk("R1 reset data", 32'(rx_data), 32'd0);
    chk("R1 reset frame err", 32'(rx_frame_err), 32'd0);
    chk("R1 reset parity err", 32'(rx_parity_err), 32'd0);
    idle(4);

    // R4: 8 bits, LSB first
    send_frame(8'hA5, 1'b0, 1'b1, -1, -1, 1'b1);
    check_frame(8'hA5, 1'b0, 1'b1);
    read_out();
    // R4: 5 bits, upper bits zero
    cfg_data_len = 2'd0;
    send_frame(8'hFF, 1'b0, 1'b1, -1, -1, 1'b1);
    chk("R4 five-bit zero-extended", 32'(rx_data), 32'h1F);
    read_out();
    // R5: odd parity correct then corrupted
    cfg_data_len = 2'd2; cfg_parity_en = 1'b1; cfg_parity_odd = 1'b1;
    send_frame(8'h35, 1'b0, 1'b1, -1, -1, 1'b1);
    check_frame(8'h35, 1'b0, 1'b1);
    read_out();
    send_frame(8'h35, 1'b1, 1'b1, -1, -1, 1'b1);
    chk("R5 odd parity mismatch", 32'(rx_parity_err), 32'd1);
    read_out();
    // R6: low stop bit, character still delivered
    send_frame(8'h4C, 1'b0, 1'b0, -1, -1, 1'b1);
    check_frame(8'h4C, 1'b0, 1'b0);
    read_out();
    // R3: single wrong sample at ticks 7, 8 and 9
    cfg_parity_en = 1'b0; cfg_data_len = 2'd3;
    for (int g = 7; g <= 9; g++) begin
      send_frame(8'h5A, 1'b0, 1'b1, g - 6, g, 1'b1);
      chk("R3 majority vote", 32'(rx_data), 32'h5A);
      read_out();
    end
    // R2: short low pulses are not starts
    for (int n = 1; n <= 8; n++) begin
      for (int s = 0; s < n; s++) next_slot(1'b0);
      idle(200);
      chk("R2 short low pulse rejected", 32'(rx_valid), 32'd0);
    end
    // R8: overwrite while unread, flag held
    send_frame(8'h11, 1'b0, 1'b1, -1, -1, 1'b0);
    idle(10);
    chk("R8 flag held while unread", 32'(rx_valid), 32'd1);
    chk("R8 data held while unread", 32'(rx_data), 32'h11);
    send_frame(8'hE7, 1'b0, 1'b1, -1, -1, 1'b0);
    chk("R8 overwrite keeps flag", 32'(rx_valid), 32'd1);
    chk("R8 overwrite data", 32'(rx_data), 32'hE7);
    read_out();
    // R9: disabled receiver ignores a whole character
    #1 rx_en = 1'b0;
    send_frame(8'h00, 1'b0, 1'b1, -1, -1, 1'b0);
    chk("R9 disabled ignores line", 32'(rx_valid), 32'd0);
    // R9: disable mid-character discards it
    #1 rx_en = 1'b1;
    idle(4);
    send_bit(1'b0, -1);
    send_bit(1'b1, -1);
    send_bit(1'b0, -1);
    #1 rx_en = 1'b0;
    for (int i = 0; i < 7; i++) send_bit(1'b0, -1);
    idle(4);
    #1 rx_en = 1'b1;
    idle(200);
    chk("R9 in-flight character dropped", 32'(rx_valid), 32'd0);

    // random characters
    for (int k = 0; k < 60; k++) begin
      cfg_data_len   = 2'($urandom_range(0, 3));
      cfg_parity_en  = 1'($urandom_range(0, 1));
      cfg_parity_odd = 1'($urandom_range(0, 1));
      d  = 8'($urandom);
      pf = ($urandom_range(0, 7) == 0);
      sv = ($urandom_range(0, 7) != 0);
      gb = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 4 + cfg_data_len)) : -1;
      gs = int'($urandom_range(7, 9));
      send_frame(d, pf, sv, gb, gs, 1'b1);
      check_frame(d, pf, sv);
      read_out();
    end
    d2 = 8'h00;
    chk("R8 idle after run", 32'(rx_valid), 32'(d2));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule